// File: doc/BRIEF.md
# Boot-Sector Flash Command Controller

This block fronts a byte-wide behavioural flash array whose sectors follow an uneven boot layout. The host drives a synchronous bus with active-low chip select, write strobe and read strobe. Write cycles are decoded into command sequences for byte program, single-sector erase, whole-array erase, erase suspend, erase resume and return-to-read. An internal sequencer alone touches the array. It times each operation with parameterised counters, and it honours a per-sector lock vector, a temporary-unlock input and a low-supply inhibit.

An erase runs in three steps. First it walks the array and writes 00 to every byte of the chosen sectors. Then it waits out a timed pulse. Last it walks the array again and writes FF to those bytes. The erase may be put on hold, so that other sectors can be read or programmed, and it then picks up at the exact step and address where it stopped. While an operation runs, host reads return a status byte instead of array data. The array is scaled by the address-width parameter; the sector map always splits it into 32 equal units.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset `ready` is 1, `dout_vld` is 0, and every array byte reads 8'hFF.
- R2: A read cycle (`ce_n`=0, `oe_n`=0, `we_n`=1 at a clock edge) produces `dout` with `dout_vld`=1 after the second following edge.
- R3: The writes AA@555h, 55@2AAh, A0@555h, then data@address program one byte. `ready` is 0 from the edge of the data write until the program completes.
- R4: Programming can only clear bits: the stored byte becomes old AND new.
- R5: Reads taken while busy return {poll, toggle, 6'b0}. poll is the inverse of bit 7 of the byte being programmed, and 0 during an erase. toggle starts at 0 after reset and flips on every status read.
- R6: The writes AA@555h, 55@2AAh, 80@555h, AA@555h, 55@2AAh, then 30 at any address of a sector erase only that sector. Top-boot map in 1/32 units: sectors of 8,8,8,4,1,1,2 units from address 0 upward; bottom-boot reverses this order.
- R7: The same sequence ending in 10@555h erases every sector that is not locked.
- R8: An erase writes 00 to every byte of its sectors before any byte is set to FF.
- R9: A locked sector (`prot` bit = 1) ignores program and erase while `unprot_tmp` is 0. With `unprot_tmp`=1 the lock is lifted.
- R10: While `low_vcc` is 1, no write cycle is accepted.
- R11: A broken sequence, or F0 at any step before the program data, returns the decoder to read mode with no effect.
- R12: B0 during an erase suspends it and raises `ready`. Reads of non-erasing sectors then return data, reads of erasing sectors return status, and programs are accepted only outside the erasing sectors. 30 resumes the erase from where it stopped.
- R13: `abort_n` low at an edge ends any operation, clears suspend and raises `ready` at that edge. Array contents already written are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of controller state |
| abort_n | input | 1 | Active-low operation abort, back to read mode |
| ce_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write strobe |
| oe_n | input | 1 | Active-low read strobe |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data or status byte |
| dout_vld | output | 1 | dout holds the result of a read |
| ready | output | 1 | 1 when no program or erase is running |
| prot | input | 7 | Per-sector lock bits |
| unprot_tmp | input | 1 | Lifts all sector locks while 1 |
| low_vcc | input | 1 | Low-supply flag, blocks writes |

## Verification
Read results arrive two edges after the read cycle. The bench's read task queues each expected byte at issue time, and a monitor compares it on the falling edge after `dout_vld` rises. A command takes effect at the edge of its last write, so `ready` is sampled on the falling edge right after that write, where it must already be low, or stay high for an ignored command. Completion takes a variable number of cycles, so the bench waits for `ready` with a bound and only then reads back. The toggle bit is tracked in the bench by counting its own status reads.

// File: rtl/flash_cc_pkg.sv
package flash_cc_pkg;
  localparam int NSECT  = 7;
  localparam int SECT_W = 3;

  typedef enum logic [2:0] {
    OP_NONE, OP_PROG, OP_SERASE, OP_CERASE, OP_SUSP, OP_RESUME
  } op_e;

  typedef enum logic [2:0] {
    EN_IDLE, EN_PRD, EN_PWAIT, EN_PWR, EN_PRE, EN_PULSE, EN_WIPE, EN_SUSP
  } eng_e;
endpackage

// File: rtl/flash_cc_sectmap.sv
module flash_cc_sectmap #(
  parameter int TOP_BOOT = 1
) (
  input  logic [4:0] unit,
  output logic [2:0] sect
);
  generate
    if (TOP_BOOT != 0) begin : g_top
      always_comb begin
        if (unit < 5'd8)       sect = 3'd0;
        else if (unit < 5'd16) sect = 3'd1;
        else if (unit < 5'd24) sect = 3'd2;
        else if (unit < 5'd28) sect = 3'd3;
        else if (unit == 5'd28) sect = 3'd4;
        else if (unit == 5'd29) sect = 3'd5;
        else                   sect = 3'd6;
      end
    end else begin : g_bot
      always_comb begin
        if (unit < 5'd2)       sect = 3'd0;
        else if (unit == 5'd2) sect = 3'd1;
        else if (unit == 5'd3) sect = 3'd2;
        else if (unit < 5'd8)  sect = 3'd3;
        else if (unit < 5'd16) sect = 3'd4;
        else if (unit < 5'd24) sect = 3'd5;
        else                   sect = 3'd6;
      end
    end
  endgenerate
endmodule

// File: rtl/flash_cc_array.sv
module flash_cc_array #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] q
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    q <= mem[raddr];
  end
endmodule

// File: rtl/flash_cc_decode.sv
module flash_cc_decode
  import flash_cc_pkg::*;
#(
  parameter int              DATA_W   = 8,
  parameter int              KEY_W    = 11,
  parameter logic [KEY_W-1:0] UNLOCK_A = 11'h555,
  parameter logic [KEY_W-1:0] UNLOCK_B = 11'h2AA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort,
  input  logic              wr,
  input  logic              accept_seq,
  input  logic              erasing,
  input  logic [KEY_W-1:0]  akey,
  input  logic [DATA_W-1:0] data,
  output op_e               op
);
  localparam logic [DATA_W-1:0] K_AA = DATA_W'(8'hAA);
  localparam logic [DATA_W-1:0] K_55 = DATA_W'(8'h55);
  localparam logic [DATA_W-1:0] K_A0 = DATA_W'(8'hA0);
  localparam logic [DATA_W-1:0] K_80 = DATA_W'(8'h80);
  localparam logic [DATA_W-1:0] K_10 = DATA_W'(8'h10);
  localparam logic [DATA_W-1:0] K_30 = DATA_W'(8'h30);
  localparam logic [DATA_W-1:0] K_B0 = DATA_W'(8'hB0);
  localparam logic [DATA_W-1:0] K_F0 = DATA_W'(8'hF0);

  typedef enum logic [2:0] {D_IDLE, D_U1, D_U2, D_PA, D_E1, D_E2, D_E3} dst_e;
  dst_e st, st_d;

  logic at_a, at_b;
  assign at_a = (akey == UNLOCK_A);
  assign at_b = (akey == UNLOCK_B);

  always_comb begin
    st_d = st;
    op   = OP_NONE;
    if (wr) begin
      st_d = D_IDLE;
      if (!accept_seq) begin
        if (erasing && data == K_B0) op = OP_SUSP;
      end else if (st == D_PA) begin
        op = OP_PROG;
      end else if (data != K_F0) begin
        case (st)
          D_IDLE: begin
            if (at_a && data == K_AA) st_d = D_U1;
            else if (data == K_B0)    op = OP_SUSP;
            else if (data == K_30)    op = OP_RESUME;
          end
          D_U1: if (at_b && data == K_55) st_d = D_U2;
          D_U2: begin
            if (at_a && data == K_A0)      st_d = D_PA;
            else if (at_a && data == K_80) st_d = D_E1;
          end
          D_E1: if (at_a && data == K_AA) st_d = D_E2;
          D_E2: if (at_b && data == K_55) st_d = D_E3;
          D_E3: begin
            if (at_a && data == K_10) op = OP_CERASE;
            else if (data == K_30)    op = OP_SERASE;
          end
          default: st_d = D_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || abort) st <= D_IDLE;
    else              st <= st_d;
  end
endmodule

// File: rtl/flash_cc_engine.sv
module flash_cc_engine
  import flash_cc_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 8,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort,
  input  op_e               op,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [DATA_W-1:0] op_data,
  input  logic [SECT_W-1:0] op_sect,
  input  logic [SECT_W-1:0] ea_sect,
  input  logic [NSECT-1:0]  allow,
  input  logic [DATA_W-1:0] rd_q,
  output logic              busy_q,
  output logic              accept_seq,
  output logic              erasing,
  output logic              susp,
  output logic              prog_act,
  output logic              prog_msb,
  output logic [NSECT-1:0]  emask,
  output logic [ADDR_W-1:0] ea,
  output logic [ADDR_W-1:0] pa,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam int MAXC  = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CNT_W = $clog2(MAXC) + 1;
  localparam logic [ADDR_W-1:0] LAST = '1;

  eng_e st, st_d, eph;
  logic [CNT_W-1:0]  cnt, ecnt;
  logic [DATA_W-1:0] pd;
  logic              in_susp;
  logic              hold;

  assign hold       = (op == OP_SUSP) || abort;
  assign accept_seq = (st == EN_IDLE) || (st == EN_SUSP);
  assign erasing    = (st == EN_PRE) || (st == EN_PULSE) || (st == EN_WIPE);
  assign susp       = (st == EN_SUSP);
  assign prog_act   = (st == EN_PRD) || (st == EN_PWAIT) || (st == EN_PWR);
  assign prog_msb   = pd[DATA_W-1];

  always_comb begin
    st_d = st;
    case (st)
      EN_IDLE: begin
        if (op == OP_PROG && allow[op_sect]) st_d = EN_PRD;
        else if ((op == OP_SERASE && allow[op_sect]) ||
                 (op == OP_CERASE && |allow)) st_d = EN_PRE;
      end
      EN_SUSP: begin
        if (op == OP_PROG && allow[op_sect] && !emask[op_sect]) st_d = EN_PRD;
        else if (op == OP_RESUME) st_d = eph;
      end
      EN_PRD:   st_d = EN_PWAIT;
      EN_PWAIT: if (cnt == CNT_W'(PROG_CYC - 1)) st_d = EN_PWR;
      EN_PWR:   st_d = in_susp ? EN_SUSP : EN_IDLE;
      EN_PRE: begin
        if (op == OP_SUSP)  st_d = EN_SUSP;
        else if (ea == LAST) st_d = EN_PULSE;
      end
      EN_PULSE: begin
        if (op == OP_SUSP) st_d = EN_SUSP;
        else if (ecnt == CNT_W'(ERASE_CYC - 1)) st_d = EN_WIPE;
      end
      EN_WIPE: begin
        if (op == OP_SUSP)  st_d = EN_SUSP;
        else if (ea == LAST) st_d = EN_IDLE;
      end
      default: st_d = EN_IDLE;
    endcase
    if (abort) st_d = EN_IDLE;
  end

  always_comb begin
    mem_we    = 1'b0;
    mem_waddr = ea;
    mem_wdata = '0;
    case (st)
      EN_PWR: begin
        mem_we    = !abort;
        mem_waddr = pa;
        mem_wdata = rd_q & pd;
      end
      EN_PRE:  mem_we = emask[ea_sect] && !hold;
      EN_WIPE: begin
        mem_we    = emask[ea_sect] && !hold;
        mem_wdata = '1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= EN_IDLE;
      eph     <= EN_PRE;
      busy_q  <= 1'b0;
      emask   <= '0;
      ea      <= '0;
      pa      <= '0;
      pd      <= '0;
      cnt     <= '0;
      ecnt    <= '0;
      in_susp <= 1'b0;
    end else begin
      st     <= st_d;
      busy_q <= !((st_d == EN_IDLE) || (st_d == EN_SUSP));
      case (st)
        EN_IDLE: begin
          if (st_d == EN_PRD) begin
            pa      <= op_addr;
            pd      <= op_data;
            cnt     <= '0;
            in_susp <= 1'b0;
          end else if (st_d == EN_PRE) begin
            emask <= (op == OP_CERASE) ? allow : (NSECT'(1) << op_sect);
            ea    <= '0;
            ecnt  <= '0;
            eph   <= EN_PRE;
          end
        end
        EN_SUSP: begin
          if (st_d == EN_PRD) begin
            pa      <= op_addr;
            pd      <= op_data;
            cnt     <= '0;
            in_susp <= 1'b1;
          end
        end
        EN_PWAIT: cnt <= cnt + 1'b1;
        EN_PRE: begin
          if (op == OP_SUSP) eph <= EN_PRE;
          else               ea  <= ea + 1'b1;
        end
        EN_PULSE: begin
          if (op == OP_SUSP) eph  <= EN_PULSE;
          else               ecnt <= ecnt + 1'b1;
        end
        EN_WIPE: begin
          if (op == OP_SUSP) eph <= EN_WIPE;
          else               ea  <= ea + 1'b1;
        end
        default: ;
      endcase
      if (st_d == EN_IDLE) emask <= '0;
    end
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cc_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 8,
  parameter int TOP_BOOT  = 1,
  parameter int PROG_CYC  = 8,
  parameter int ERASE_CYC = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_vld,
  output logic              ready,
  input  logic [6:0]        prot,
  input  logic              unprot_tmp,
  input  logic              low_vcc
);
  localparam int KEY_W = 11;

  logic abort, rd_cyc, wr_cyc;
  assign abort  = !abort_n;
  assign rd_cyc = !ce_n && !oe_n && we_n;
  assign wr_cyc = !ce_n && !we_n && oe_n && !low_vcc;

  logic [SECT_W-1:0] host_sect, ea_sect;
  logic [NSECT-1:0]  allow, emask;
  logic [ADDR_W-1:0] ea, pa, arr_waddr, raddr;
  logic [DATA_W-1:0] arr_wdata, arr_q;
  logic              arr_we, busy_q, accept_seq, erasing, susp, prog_act, prog_msb;
  op_e               op;

  assign allow = ~prot | {NSECT{unprot_tmp}};

  flash_cc_sectmap #(.TOP_BOOT(TOP_BOOT)) u_map_host (
    .unit(addr[ADDR_W-1 -: 5]), .sect(host_sect));
  flash_cc_sectmap #(.TOP_BOOT(TOP_BOOT)) u_map_walk (
    .unit(ea[ADDR_W-1 -: 5]), .sect(ea_sect));

  flash_cc_decode #(.DATA_W(DATA_W), .KEY_W(KEY_W)) u_dec (
    .clk(clk), .rst(rst), .abort(abort), .wr(wr_cyc),
    .accept_seq(accept_seq), .erasing(erasing),
    .akey(addr[KEY_W-1:0]), .data(din), .op(op));

  flash_cc_engine #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) u_eng (
    .clk(clk), .rst(rst), .abort(abort), .op(op), .op_addr(addr), .op_data(din),
    .op_sect(host_sect), .ea_sect(ea_sect), .allow(allow), .rd_q(arr_q),
    .busy_q(busy_q), .accept_seq(accept_seq), .erasing(erasing), .susp(susp),
    .prog_act(prog_act), .prog_msb(prog_msb), .emask(emask), .ea(ea), .pa(pa),
    .mem_we(arr_we), .mem_waddr(arr_waddr), .mem_wdata(arr_wdata));

  assign raddr = prog_act ? pa : addr;

  flash_cc_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk(clk), .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
    .raddr(raddr), .q(arr_q));

  logic rd_pend, stat_sel, poll_q, tog_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend  <= 1'b0;
      stat_sel <= 1'b0;
      poll_q   <= 1'b0;
      tog_q    <= 1'b0;
      dout     <= '0;
      dout_vld <= 1'b0;
    end else begin
      rd_pend  <= rd_cyc;
      stat_sel <= busy_q || (susp && emask[host_sect]);
      poll_q   <= prog_act ? ~prog_msb : 1'b0;
      dout_vld <= rd_pend;
      if (rd_pend) begin
        if (stat_sel) begin
          dout  <= {poll_q, tog_q, {(DATA_W-2){1'b0}}};
          tog_q <= ~tog_q;
        end else begin
          dout <= arr_q;
        end
      end
    end
  end

  assign ready = !busy_q;
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic abort_n,
  input logic ce_n,
  input logic we_n,
  input logic oe_n,
  input logic low_vcc,
  input logic ready,
  input logic dout_vld,
  input logic arr_we
);
  assert_read_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && !oe_n && we_n) |=> ##1 dout_vld);

  assert_write_only_busy_R3: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> !ready);

  assert_lowvcc_no_start_R10: assert property (@(posedge clk) disable iff (rst)
    (low_vcc && ready) |=> ready);

  assert_abort_ready_R13: assert property (@(posedge clk) disable iff (rst)
    !abort_n |=> ready);
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .abort_n(abort_n), .ce_n(ce_n), .we_n(we_n),
  .oe_n(oe_n), .low_vcc(low_vcc), .ready(ready), .dout_vld(dout_vld),
  .arr_we(arr_we));

// File: tb/flash_cmd_ctrl_tb.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        abort_n = 1'b1, ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [11:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        dout_vld, ready;
  logic [6:0]  prot = '0;
  logic        unprot_tmp = 1'b0, low_vcc = 1'b0;

  always #2.5 clk = ~clk;

  flash_cmd_ctrl u_dut (
    .clk(clk), .rst(rst), .abort_n(abort_n), .ce_n(ce_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .din(din), .dout(dout), .dout_vld(dout_vld),
    .ready(ready), .prot(prot), .unprot_tmp(unprot_tmp), .low_vcc(low_vcc));

  int checks = 0, errors = 0;
  logic tog_m = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (dout_vld) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected dout_vld", dout, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(dout == e, t, dout, e);
      end
    end
  end

  task automatic bus_wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic rd(input logic [11:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  function automatic logic [7:0] stat(input logic poll);
    stat = {poll, tog_m, 6'b0};
    tog_m = ~tog_m;
  endfunction

  task automatic prog(input logic [11:0] a, input logic [7:0] d);
    bus_wr(12'h555, 8'hAA); bus_wr(12'h2AA, 8'h55);
    bus_wr(12'h555, 8'hA0); bus_wr(a, d);
  endtask

  task automatic erase_cmd(input logic [11:0] a, input logic [7:0] code);
    bus_wr(12'h555, 8'hAA); bus_wr(12'h2AA, 8'h55); bus_wr(12'h555, 8'h80);
    bus_wr(12'h555, 8'hAA); bus_wr(12'h2AA, 8'h55); bus_wr(a, code);
  endtask

  task automatic wait_ready(input string req);
    int n = 0;
    while (!ready && n < 20000) begin
      @(negedge clk);
      n++;
    end
    check(ready, req, ready, 1);
  endtask

  task automatic drain();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    check(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(ready == 1'b1, "R1 ready after reset", ready, 1);
    check(dout_vld == 1'b0, "R1 no read data", dout_vld, 0);
    rd(12'h123, 8'hFF, "R1 erased byte");
    rd(12'hFFF, 8'hFF, "R1 R2 top byte");
    drain();

    // R3 program with R5 status reads
    prog(12'h010, 8'h5A);
    check(ready == 1'b0, "R3 busy after data write", ready, 0);
    rd(12'h010, stat(1'b1), "R5 program status poll");
    rd(12'h010, stat(1'b1), "R5 toggle flips");
    wait_ready("R3 program completes");
    rd(12'h010, 8'h5A, "R3 programmed byte");
    // R4 bits only cleared
    prog(12'h010, 8'hF0);
    wait_ready("R4 program completes");
    rd(12'h010, 8'h50, "R4 AND of old and new");
    prog(12'h3F0, 8'hA5);
    wait_ready("R3 second program");
    drain();

    // R9 lock and temporary unlock
    prot = 7'b0000010;
    prog(12'h400, 8'h12);
    check(ready == 1'b1, "R9 locked sector not started", ready, 1);
    rd(12'h400, 8'hFF, "R9 locked byte unchanged");
    unprot_tmp = 1'b1;
    prog(12'h400, 8'h12);
    check(ready == 1'b0, "R9 unlock starts program", ready, 0);
    wait_ready("R9 program completes");
    rd(12'h400, 8'h12, "R9 programmed under unlock");
    unprot_tmp = 1'b0;
    prot = '0;
    drain();

    // R10 low supply
    low_vcc = 1'b1;
    prog(12'h020, 8'h00);
    check(ready == 1'b1, "R10 no start under low supply", ready, 1);
    low_vcc = 1'b0;
    rd(12'h020, 8'hFF, "R10 byte unchanged");
    drain();

    // R11 broken sequence and F0
    bus_wr(12'h555, 8'hAA); bus_wr(12'h2AA, 8'h12);
    bus_wr(12'h555, 8'hA0); bus_wr(12'h030, 8'h00);
    check(ready == 1'b1, "R11 broken sequence idle", ready, 1);
    rd(12'h030, 8'hFF, "R11 broken sequence no write");
    bus_wr(12'h555, 8'hAA); bus_wr(12'h2AA, 8'h55); bus_wr(12'h555, 8'hF0);
    bus_wr(12'h555, 8'hA0); bus_wr(12'h031, 8'h00);
    check(ready == 1'b1, "R11 F0 back to read", ready, 1);
    rd(12'h031, 8'hFF, "R11 F0 no write");
    drain();

    // R6 sector erase of the one-unit sector 0xE00-0xE7F
    prog(12'hE00, 8'h11); wait_ready("R6 setup");
    prog(12'hE7F, 8'h22); wait_ready("R6 setup");
    prog(12'hE80, 8'h33); wait_ready("R6 setup");
    prog(12'hDFF, 8'h44); wait_ready("R6 setup");
    erase_cmd(12'hE40, 8'h30);
    check(ready == 1'b0, "R6 erase busy", ready, 0);
    rd(12'hE40, stat(1'b0), "R5 erase status poll 0");
    wait_ready("R6 erase completes");
    rd(12'hE00, 8'hFF, "R6 sector low end erased");
    rd(12'hE7F, 8'hFF, "R6 sector high end erased");
    rd(12'hE80, 8'h33, "R6 next sector kept");
    rd(12'hDFF, 8'h44, "R6 previous sector kept");
    drain();

    // R12 suspend and resume on sector 0xF00-0xFFF
    prog(12'h800, 8'h66); wait_ready("R12 setup");
    prog(12'hF10, 8'h77); wait_ready("R12 setup");
    erase_cmd(12'hF00, 8'h30);
    repeat (3950) @(negedge clk);
    bus_wr(12'h000, 8'hB0);
    check(ready == 1'b1, "R12 suspend raises ready", ready, 1);
    rd(12'h800, 8'h66, "R12 read other sector");
    rd(12'hF10, stat(1'b0), "R12 erasing sector status");
    prog(12'h801, 8'h0F);
    check(ready == 1'b0, "R12 program while suspended", ready, 0);
    wait_ready("R12 suspended program done");
    rd(12'h801, 8'h0F, "R12 suspended program data");
    prog(12'hF20, 8'h00);
    check(ready == 1'b1, "R12 program into erasing sector ignored", ready, 1);
    bus_wr(12'h000, 8'h30);
    check(ready == 1'b0, "R12 resume busy", ready, 0);
    wait_ready("R12 resumed erase done");
    rd(12'hF10, 8'hFF, "R12 erase finished");
    rd(12'hF20, 8'hFF, "R12 erase finished second byte");
    rd(12'h800, 8'h66, "R12 other sector kept");
    rd(12'h801, 8'h0F, "R12 other sector kept 2");
    drain();

    // R13 abort mid preprogram, shows R8 ordering
    erase_cmd(12'h100, 8'h30);
    repeat (600) @(negedge clk);
    abort_n = 1'b0;
    @(negedge clk);
    abort_n = 1'b1;
    check(ready == 1'b1, "R13 abort raises ready", ready, 1);
    rd(12'h010, 8'h00, "R8 walked byte preprogrammed to 00");
    rd(12'h3F0, 8'hA5, "R13 unwalked byte kept");
    drain();

    // R7 chip erase with sector 0 locked
    prot = 7'b0000001;
    erase_cmd(12'h555, 8'h10);
    check(ready == 1'b0, "R7 chip erase busy", ready, 0);
    wait_ready("R7 chip erase done");
    prot = '0;
    rd(12'h010, 8'h00, "R7 locked sector kept");
    rd(12'h3F0, 8'hA5, "R7 locked sector kept 2");
    rd(12'h400, 8'hFF, "R7 sector 1 erased");
    rd(12'h800, 8'hFF, "R7 sector 2 erased");
    rd(12'hDFF, 8'hFF, "R7 sector 3 erased");
    rd(12'hE80, 8'hFF, "R7 sector 5 erased");
    drain();
    check(exp_q.size() == 0, "R2 all reads returned", exp_q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule